// File: doc/BRIEF.md
# Hardwired Step-Sequenced Control Unit

This block is the sequencing logic of a processor built around one shared internal bus. A step counter is decoded into one-hot timing lines, the opcode held in the instruction register is decoded separately, and a combinational encoder forms each control strobe as an OR of step-and-opcode products. The strobes choose which register drives the bus, which registers latch it, whether memory is read, and how the ALU is set up. The registers, ALU and memory sit outside the block.

Every instruction begins with the same three fetch steps: compute PC+1 while the instruction word is read, write back PC, then load IR. Execution steps follow for two opcodes: an add that takes one operand from memory at the address held in R3 and adds it into R1, and an unconditional relative branch. Any other opcode ends at the fourth step, so the next fetch starts at once. While a step waits for memory, the counter holds until the memory-complete input is high. The counter also holds while the run input is low. End sends it back to the first step.

Top module: `hwControl`

## Requirements
- R1: Reset (asynchronous, active high) forces the first step, and the outputs then show the first-step word for any opcode.
- R2: First step: the bus source is PC (busOut bit 0). MAR (regIn bit 2) and Z (regIn bit 4) load. memRead, clearY and carryIn are 1 and aluSel is 0 (add). All other strobes are 0.
- R3: Second step: Z (busOut bit 2) drives the bus into PC (regIn bit 0) and waits for memory. Third step: MDR (busOut bit 1) drives the bus into IR (regIn bit 1). IR loads in no other step.
- R4: Opcode 1 (add). Step 4: R3 (busOut bit 4) into MAR with memRead. Step 5: R1 (busOut bit 3) into Y (regIn bit 3), waiting for memory. Step 6: MDR into Z with aluSel 0. Step 7: Z into R1 (regIn bit 5) with endStep.
- R5: Opcode 2 (branch). Step 4: PC into Y. Step 5: the IR offset field (busOut bit 5) into Z with aluSel 0. Step 6: Z into PC with endStep.
- R6: Any opcode other than 1 or 2 gives endStep at step 4 with every other strobe 0.
- R7: In a waiting step with mfc low, the step and all its strobes are held. The counter advances on the first clock edge with mfc high. In steps that do not wait, mfc has no effect.
- R8: While run is low the step does not change, whatever mfc or endStep do.
- R9: When endStep is high with run high, the next edge returns the counter to the first step.
- R10: At most one bus source is enabled at any time, and memWrite is always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Asynchronous reset, active high |
| run | input | 1 | Lets the step counter advance |
| opcode | input | 4 | Opcode field of the instruction register |
| mfc | input | 1 | Memory operation complete |
| busOut | output | 6 | One-hot bus source: PC, MDR, Z, R1, R3, IR offset |
| regIn | output | 6 | Register load enables: PC, IR, MAR, Y, Z, R1 |
| memRead | output | 1 | Start a memory read |
| memWrite | output | 1 | Start a memory write |
| aluSel | output | 2 | ALU function, 0 = add |
| carryIn | output | 1 | ALU carry-in |
| clearY | output | 1 | Force the Y operand to zero |
| endStep | output | 1 | Last step of the current instruction |

## Verification
All strobes are combinational from the step register and the opcode. They are therefore due in the same cycle that the step becomes current, and the bench samples them one time unit after each falling edge. The bench keeps its own step number. It moves that number on at each rising edge according to run, mfc and the expected endStep, so a stall, a pause or a restart shows up in the word checked one cycle later. Every opcode is swept against memory delays of zero to two cycles, with a run pause placed at a different step each time.

// File: rtl/ctrlPkg.sv
package ctrlPkg;
  localparam int OP_W  = 4;
  localparam int SRC_N = 6;
  localparam int DST_N = 6;
  localparam int NSTEP = 7;   // longest sequence (add) uses seven steps

  // bus source positions
  localparam int SRC_PC  = 0;
  localparam int SRC_MDR = 1;
  localparam int SRC_Z   = 2;
  localparam int SRC_R1  = 3;
  localparam int SRC_R3  = 4;
  localparam int SRC_OFF = 5;

  // load-enable positions
  localparam int DST_PC  = 0;
  localparam int DST_IR  = 1;
  localparam int DST_MAR = 2;
  localparam int DST_Y   = 3;
  localparam int DST_Z   = 4;
  localparam int DST_R1  = 5;

  localparam logic [OP_W-1:0] OP_ADD = 4'h1;
  localparam logic [OP_W-1:0] OP_BR  = 4'h2;
  localparam logic [1:0]      ALU_ADD = 2'd0;

  typedef struct packed {
    logic [SRC_N-1:0] busOut;
    logic [DST_N-1:0] regIn;
    logic             memRead;
    logic             memWrite;
    logic [1:0]       aluSel;
    logic             carryIn;
    logic             clearY;
    logic             endStep;
    logic             waitMfc;
  } ctrlWord_t;
endpackage

// File: rtl/stepCounter.sv
module stepCounter #(
  parameter int STEP_W = 3,
  parameter int NSTEP  = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             mfc,
  input  logic             waitMfc,
  input  logic             endStep,
  output logic [NSTEP-1:0] tStep
);
  logic [STEP_W-1:0] cnt;

  always_ff @(posedge clk or posedge rst) begin
    if (rst)                    cnt <= '0;
    else if (!run)              cnt <= cnt;
    else if (endStep)           cnt <= '0;
    else if (waitMfc && !mfc)   cnt <= cnt;
    else                        cnt <= cnt + 1'b1;
  end

  // step decoder: one timing line per step
  for (genvar i = 0; i < NSTEP; i++) begin : g_dec
    assign tStep[i] = (cnt == STEP_W'(i));
  end

  // R1
  step_onehot_chk: assert property (@(posedge clk) disable iff (rst) $onehot(tStep));
  // R7
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (run && waitMfc && !mfc) |=> (cnt == $past(cnt)));
  // R8
  run_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !run |=> $stable(cnt));
  // R9
  end_restart_chk: assert property (@(posedge clk) disable iff (rst)
    (run && endStep) |=> (cnt == '0));
endmodule

// File: rtl/instrDecoder.sv
module instrDecoder
  import ctrlPkg::*;
(
  input  logic [OP_W-1:0] opcode,
  output logic            isAdd,
  output logic            isBr,
  output logic            isOther
);
  always_comb begin
    isAdd   = (opcode == OP_ADD);
    isBr    = (opcode == OP_BR);
    isOther = !isAdd && !isBr;
  end
endmodule

// File: rtl/controlEncoder.sv
module controlEncoder
  import ctrlPkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [NSTEP-1:0] tStep,
  input  logic             isAdd,
  input  logic             isBr,
  input  logic             isOther,
  output ctrlWord_t        cw
);
  logic t1, t2, t3, t4, t5, t6, t7;
  assign {t7, t6, t5, t4, t3, t2, t1} = tStep;

  always_comb begin
    cw = '0;
    cw.busOut[SRC_PC]  = t1 | (t4 & isBr);
    cw.busOut[SRC_MDR] = t3 | (t6 & isAdd);
    cw.busOut[SRC_Z]   = t2 | (t7 & isAdd) | (t6 & isBr);
    cw.busOut[SRC_R1]  = t5 & isAdd;
    cw.busOut[SRC_R3]  = t4 & isAdd;
    cw.busOut[SRC_OFF] = t5 & isBr;

    cw.regIn[DST_PC]   = t2 | (t6 & isBr);
    cw.regIn[DST_IR]   = t3;
    cw.regIn[DST_MAR]  = t1 | (t4 & isAdd);
    cw.regIn[DST_Y]    = (t5 & isAdd) | (t4 & isBr);
    cw.regIn[DST_Z]    = t1 | (t6 & isAdd) | (t5 & isBr);
    cw.regIn[DST_R1]   = t7 & isAdd;

    cw.memRead  = t1 | (t4 & isAdd);
    cw.memWrite = 1'b0;
    cw.aluSel   = ALU_ADD;
    cw.carryIn  = t1;
    cw.clearY   = t1;
    cw.endStep  = (t7 & isAdd) | (t6 & isBr) | (t4 & isOther);
    cw.waitMfc  = t2 | (t5 & isAdd);
  end

  // R10
  single_source_chk: assert property (@(posedge clk) disable iff (rst) $onehot0(cw.busOut));
  // R3
  ir_load_chk: assert property (@(posedge clk) disable iff (rst)
    cw.regIn[DST_IR] |-> (cw.busOut[SRC_MDR] && !cw.endStep));
  // R2
  carry_fetch_chk: assert property (@(posedge clk) disable iff (rst)
    cw.carryIn |-> (cw.busOut[SRC_PC] && cw.regIn[DST_Z] && cw.memRead));
endmodule

// File: rtl/hwControl.sv
module hwControl
  import ctrlPkg::*;
#(
  parameter int STEP_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [OP_W-1:0]  opcode,
  input  logic             mfc,
  output logic [SRC_N-1:0] busOut,
  output logic [DST_N-1:0] regIn,
  output logic             memRead,
  output logic             memWrite,
  output logic [1:0]       aluSel,
  output logic             carryIn,
  output logic             clearY,
  output logic             endStep
);
  logic [NSTEP-1:0] tStep;
  logic isAdd, isBr, isOther;
  ctrlWord_t cw;

  stepCounter #(.STEP_W(STEP_W), .NSTEP(NSTEP)) u_steps (
    .clk(clk), .rst(rst), .run(run), .mfc(mfc),
    .waitMfc(cw.waitMfc), .endStep(cw.endStep), .tStep(tStep)
  );

  instrDecoder u_idec (
    .opcode(opcode), .isAdd(isAdd), .isBr(isBr), .isOther(isOther)
  );

  controlEncoder u_enc (
    .clk(clk), .rst(rst), .tStep(tStep),
    .isAdd(isAdd), .isBr(isBr), .isOther(isOther), .cw(cw)
  );

  assign busOut   = cw.busOut;
  assign regIn    = cw.regIn;
  assign memRead  = cw.memRead;
  assign memWrite = cw.memWrite;
  assign aluSel   = cw.aluSel;
  assign carryIn  = cw.carryIn;
  assign clearY   = cw.clearY;
  assign endStep  = cw.endStep;
endmodule

// File: tb/hwControl_tb.sv
module hwControl_tb;
  localparam int PERIOD = 10;

  logic clk = 1'b0;
  logic rst, run, mfc;
  logic [3:0] opcode;
  logic [5:0] busOut, regIn;
  logic memRead, memWrite, carryIn, clearY, endStep;
  logic [1:0] aluSel;

  int checks = 0;
  int fails  = 0;

  always #(PERIOD/2) clk = ~clk;

  hwControl u_dut (
    .clk(clk), .rst(rst), .run(run), .opcode(opcode), .mfc(mfc),
    .busOut(busOut), .regIn(regIn), .memRead(memRead), .memWrite(memWrite),
    .aluSel(aluSel), .carryIn(carryIn), .clearY(clearY), .endStep(endStep)
  );

  // word layout: {bus[5:0], ld[5:0], rd, wr, alu[1:0], cin, clrY, end}
  function automatic logic [18:0] expWord(int s, logic [3:0] op);
    logic [5:0] b, l;
    logic rd, cin, cy, en;
    b = '0; l = '0; rd = 0; cin = 0; cy = 0; en = 0;
    case (s)
      1: begin b[0] = 1; l[2] = 1; l[4] = 1; rd = 1; cin = 1; cy = 1; end  // R2
      2: begin b[2] = 1; l[0] = 1; end                                     // R3
      3: begin b[1] = 1; l[1] = 1; end                                     // R3
      default: begin
        if (op == 4'h1) begin                                              // R4
          case (s)
            4: begin b[4] = 1; l[2] = 1; rd = 1; end
            5: begin b[3] = 1; l[3] = 1; end
            6: begin b[1] = 1; l[4] = 1; end
            7: begin b[2] = 1; l[5] = 1; en = 1; end
            default: ;
          endcase
        end else if (op == 4'h2) begin                                     // R5
          case (s)
            4: begin b[0] = 1; l[3] = 1; end
            5: begin b[5] = 1; l[4] = 1; end
            6: begin b[2] = 1; l[0] = 1; en = 1; end
            default: ;
          endcase
        end else if (s == 4) en = 1;                                       // R6
      end
    endcase
    return {b, l, rd, 1'b0, 2'b00, cin, cy, en};
  endfunction

  function automatic logic expWait(int s, logic [3:0] op);
    return (s == 2) || (s == 5 && op == 4'h1);
  endfunction

  function automatic string tagFor(int s, logic [3:0] op, logic stalled, logic paused);
    if (paused)  return "R8";
    if (stalled) return "R7";
    if (s == 1)  return "R2";
    if (s <= 3)  return "R3";
    if (op == 4'h1) return "R4";
    if (op == 4'h2) return "R5";
    return "R6";
  endfunction

  task automatic check(string tag, logic [18:0] exp);
    logic [18:0] act;
    act = {busOut, regIn, memRead, memWrite, aluSel, carryIn, clearY, endStep};
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: word %b expected %b", tag, act, exp);
    end
  endtask

  // one instruction from T1 back to T1
  task automatic runInstr(logic [3:0] op, int delay, int pauseAt);
    int s = 1;
    int waited = 0;
    int pauseLeft = 2;
    bit done = 0;
    bit stalled, paused;
    int nxt;
    opcode = op;
    while (!done) begin
      @(negedge clk);
      paused = (s == pauseAt) && (pauseLeft > 0);
      if (paused) pauseLeft--;
      run = !paused;
      if (expWait(s, op)) mfc = (waited >= delay);
      else mfc = 1'b0;                 // R7: no effect outside waiting steps
      stalled = expWait(s, op) && !mfc;
      if (stalled && !paused) waited++;
      #1;
      check(tagFor(s, op, stalled, paused), expWord(s, op));
      if (paused) nxt = s;
      else if (expWord(s, op)[0]) begin nxt = 1; done = 1; end  // R9
      else if (stalled) nxt = s;
      else nxt = s + 1;
      if (nxt != s) waited = 0;
      s = nxt;
    end
  endtask

  initial begin
    #(PERIOD * 20000);
    fails++;
    checks++;
    $display("FAIL watchdog: run did not end");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    rst = 1'b1; run = 1'b0; mfc = 1'b0; opcode = 4'h1;
    repeat (3) @(negedge clk);
    #1;
    check("R1", expWord(1, 4'h1));
    @(negedge clk);
    rst = 1'b0;

    for (int op = 0; op < 16; op++) begin
      for (int d = 0; d < 3; d++) begin
        runInstr(4'(op), d, ((op + d) % 3) + 3);
        // R9: after the final step the word is the first-step word again
        @(negedge clk);
        run = 1'b0;
        #1;
        check("R9", expWord(1, 4'(op)));
      end
    end

    // R1: reset in the middle of an add sequence
    opcode = 4'h1; run = 1'b1; mfc = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    check("R4", expWord(5, 4'h1));
    rst = 1'b1;
    #1;
    check("R1", expWord(1, 4'h1));
    @(negedge clk);
    rst = 1'b0;
    #1;
    check("R1", expWord(1, 4'h1));

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule